// File: doc/BRIEF.md
# Serial Path-Overhead Access Port

This block serves a serial channel through which an outside source supplies the path-overhead bytes for an outgoing frame. It creates the channel timing itself. It drives a bit clock out in inverted form and a sync pulse once per frame. It shifts in frames of nine bytes, each byte most significant bit first, and checks a parity bit that covers the frame before. Each received byte is held until the whole frame has arrived.

For every overhead byte slot, a selector forms the value that the frame builder downstream will send. The first choice is a register value. If that is not enabled, the received channel byte is used. If neither is enabled, a global default of all zeros or all ones is used. A parity mismatch sets a sticky event, and a mask bit can keep that event from raising the interrupt.

The host supplies `bit_en_i` as a strobe at twice the channel bit rate. At the nominal channel rate of 576 kbit/s, this is 72 bits per frame at 8 kHz. Two strobes make up one bit period.

Top module: `poh_serial_port`

## Requirements
- R1: After reset `ch_clk_o` is high. Each `bit_en_i` strobe toggles it. The strobe that finds it high is the sample strobe: on that edge `ser_i` is taken in and `ch_clk_o` falls. Between strobes `ch_clk_o` does not change.
- R2: `ch_sync_o` is high from reset or from the sample of a frame's last bit until the sample of the next frame's first bit, which is the MSB of slot 0. It is low for the other 71 bits.
- R3: Bits arrive MSB first and fill slots 0..8 in order. Slot k sits at bits [8k+7:8k] of the byte buses. A slot whose channel enable is set shows the received byte on `ovh_o`.
- R4: Bit 7 of slot 1 is the parity bit, compared with the XOR of all 72 bits of the previous frame. With `odd_par_i`=0 a mismatch is an error when the bit differs from that XOR. With `odd_par_i`=1 it is an error when the bit equals that XOR. An error sets `par_err_o`.
- R5: After reset, no parity error is reported for the first complete frame.
- R6: `par_err_o` stays set until `err_clr_i` is pulsed high, and it then clears.
- R7: `irq_o` is `par_err_o` AND NOT `irq_mask_i`.
- R8: For each slot other than 1, the value on `ovh_o` comes from the first of these that applies. If `reg_ins_i[k]` is set, the slot of `reg_val_i` is used. Otherwise, if `ch_en_i[k]` is set, the received byte is used. Otherwise the default is used.
- R9: The default byte is 8'hFF when `dflt_ones_i`=1 and 8'h00 when it is 0.
- R10: Received bytes reach `ovh_o` only after a frame's last bit. In the middle of a frame, `ovh_o` shows the previous frame.
- R11: Slot 1 of `ovh_o` always carries the default byte, whatever `reg_ins_i[1]` and `ch_en_i[1]` hold.
- R12: Right after reset, `ch_sync_o` and `ch_clk_o` are high, and `par_err_o`, `irq_o` and `ovh_o` are zero when `dflt_ones_i`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en_i | input | 1 | Strobe at twice the bit rate |
| ser_i | input | 1 | Serial overhead data from the source |
| ch_clk_o | output | 1 | Inverted channel bit clock |
| ch_sync_o | output | 1 | Frame sync, high in the first bit period |
| odd_par_i | input | 1 | 1 selects odd parity, 0 selects even parity |
| reg_ins_i | input | 9 | Per-slot register-insert enables |
| reg_val_i | input | 72 | Per-slot register bytes |
| ch_en_i | input | 9 | Per-slot channel-byte enables |
| dflt_ones_i | input | 1 | Default byte: 1 gives all ones, 0 gives all zeros |
| irq_mask_i | input | 1 | Interrupt mask |
| err_clr_i | input | 1 | Clear pulse for the parity event (write 1 to clear) |
| ovh_o | output | 72 | Selected overhead byte per slot |
| par_err_o | output | 1 | Sticky parity-error event |
| irq_o | output | 1 | Parity interrupt |

## Verification
The first frame after reset carries a deliberately wrong parity bit. This shows that the parity check is only seeded by that frame. Later frames carry parity that is correct for even sense, wrong for even sense, correct for odd sense, and correct for even sense while odd sense is selected. Together these separate a wrong sense, a check against the wrong frame, and a missing check. Frames with distinct byte values in every slot reveal swapped slots or a reversed bit order. Checks taken in the middle of a frame reveal early commits. Setting the register, channel and default sources one against another in single slots confirms the priority order and the reserved parity slot.

// File: rtl/poh_pkg.sv
package poh_pkg;
  parameter int NBYTES   = 9;
  parameter int BYTE_W   = 8;
  parameter int PAR_SLOT = 1;
endpackage

// File: rtl/poh_timing.sv
module poh_timing #(
  parameter int NBYTES  = poh_pkg::NBYTES,
  parameter int BYTE_W  = poh_pkg::BYTE_W,
  localparam int BIT_W  = $clog2(BYTE_W),
  localparam int BYTE_IW = $clog2(NBYTES)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bit_en,
  output logic               samp_o,
  output logic [BIT_W-1:0]   bit_idx_o,
  output logic [BYTE_IW-1:0] byte_idx_o,
  output logic               frame_end_o,
  output logic               ch_clk_o,
  output logic               ch_sync_o
);
  logic               iclk_q;
  logic               sync_q;
  logic [BIT_W-1:0]   bit_q;
  logic [BYTE_IW-1:0] byte_q;
  logic               last_bit, last_byte;

  assign samp_o      = bit_en & ~iclk_q;
  assign last_bit    = (bit_q == BIT_W'(BYTE_W - 1));
  assign last_byte   = (byte_q == BYTE_IW'(NBYTES - 1));
  assign frame_end_o = samp_o & last_bit & last_byte;
  assign bit_idx_o   = bit_q;
  assign byte_idx_o  = byte_q;
  assign ch_clk_o    = ~iclk_q;
  assign ch_sync_o   = sync_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      iclk_q <= 1'b0;
      sync_q <= 1'b1;
      bit_q  <= '0;
      byte_q <= '0;
    end else begin
      if (bit_en) iclk_q <= ~iclk_q;
      if (samp_o) begin
        sync_q <= last_bit & last_byte;
        if (last_bit) begin
          bit_q  <= '0;
          byte_q <= last_byte ? '0 : byte_q + 1'b1;
        end else begin
          bit_q <= bit_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/poh_deser.sv
module poh_deser #(
  parameter int NBYTES   = poh_pkg::NBYTES,
  parameter int BYTE_W   = poh_pkg::BYTE_W,
  parameter int PAR_SLOT = poh_pkg::PAR_SLOT,
  localparam int BIT_W   = $clog2(BYTE_W),
  localparam int BYTE_IW = $clog2(NBYTES)
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           samp,
  input  logic [BIT_W-1:0]               bit_idx,
  input  logic [BYTE_IW-1:0]             byte_idx,
  input  logic                           frame_end,
  input  logic                           ser_i,
  input  logic                           odd_sel,
  output logic [NBYTES-1:0][BYTE_W-1:0]  held_o,
  output logic                           err_pulse_o
);
  logic [BYTE_W-1:0] shift_q;
  logic [BYTE_W-1:0] stage_mem [NBYTES];
  logic [NBYTES-1:0][BYTE_W-1:0] held_q;
  logic acc_q, prev_x_q, have_prev_q, par_q, commit_q, err_q;
  logic byte_done, par_cap;
  logic [BYTE_W-1:0] next_byte;

  assign next_byte   = {shift_q[BYTE_W-2:0], ser_i};
  assign byte_done   = samp && (bit_idx == BIT_W'(BYTE_W - 1));
  assign par_cap     = samp && (bit_idx == '0) && (byte_idx == BYTE_IW'(PAR_SLOT));
  assign held_o      = held_q;
  assign err_pulse_o = err_q;

  always_ff @(posedge clk) begin
    if (byte_done) stage_mem[byte_idx] <= next_byte;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      shift_q     <= '0;
      acc_q       <= 1'b0;
      prev_x_q    <= 1'b0;
      have_prev_q <= 1'b0;
      par_q       <= 1'b0;
      commit_q    <= 1'b0;
      err_q       <= 1'b0;
      held_q      <= '0;
    end else begin
      commit_q <= frame_end;
      err_q    <= 1'b0;
      if (samp) begin
        shift_q <= next_byte;
        if (par_cap) par_q <= ser_i;
        if (frame_end) begin
          acc_q       <= 1'b0;
          prev_x_q    <= acc_q ^ ser_i;
          have_prev_q <= 1'b1;
          err_q       <= have_prev_q & (par_q ^ prev_x_q ^ odd_sel);
        end else begin
          acc_q <= acc_q ^ ser_i;
        end
      end
      if (commit_q) begin
        for (int k = 0; k < NBYTES; k++) held_q[k] <= stage_mem[k];
      end
    end
  end
endmodule

// File: rtl/poh_insert_sel.sv
module poh_insert_sel #(
  parameter int NBYTES   = poh_pkg::NBYTES,
  parameter int BYTE_W   = poh_pkg::BYTE_W,
  parameter int PAR_SLOT = poh_pkg::PAR_SLOT
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [NBYTES-1:0]             reg_ins,
  input  logic [NBYTES-1:0][BYTE_W-1:0] reg_val,
  input  logic [NBYTES-1:0]             ch_en,
  input  logic                          dflt_ones,
  input  logic [NBYTES-1:0][BYTE_W-1:0] held,
  output logic [NBYTES-1:0][BYTE_W-1:0] ovh_o
);
  for (genvar g = 0; g < NBYTES; g++) begin : g_slot
    logic [BYTE_W-1:0] slot_q;
    if (g == PAR_SLOT) begin : g_par
      always_ff @(posedge clk) begin
        if (rst) slot_q <= '0;
        else     slot_q <= {BYTE_W{dflt_ones}};
      end
    end else begin : g_ovh
      always_ff @(posedge clk) begin
        if (rst)             slot_q <= '0;
        else if (reg_ins[g]) slot_q <= reg_val[g];
        else if (ch_en[g])   slot_q <= held[g];
        else                 slot_q <= {BYTE_W{dflt_ones}};
      end
    end
    assign ovh_o[g] = slot_q;
  end
endmodule

// File: rtl/poh_serial_port.sv
module poh_serial_port #(
  parameter int NBYTES   = poh_pkg::NBYTES,
  parameter int BYTE_W   = poh_pkg::BYTE_W,
  parameter int PAR_SLOT = poh_pkg::PAR_SLOT,
  localparam int BUS_W   = NBYTES * BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_en_i,
  input  logic              ser_i,
  output logic              ch_clk_o,
  output logic              ch_sync_o,
  input  logic              odd_par_i,
  input  logic [NBYTES-1:0] reg_ins_i,
  input  logic [BUS_W-1:0]  reg_val_i,
  input  logic [NBYTES-1:0] ch_en_i,
  input  logic              dflt_ones_i,
  input  logic              irq_mask_i,
  input  logic              err_clr_i,
  output logic [BUS_W-1:0]  ovh_o,
  output logic              par_err_o,
  output logic              irq_o
);
  localparam int BIT_W   = $clog2(BYTE_W);
  localparam int BYTE_IW = $clog2(NBYTES);

  logic samp, frame_end, err_pulse, evt_q;
  logic [BIT_W-1:0]   bit_idx;
  logic [BYTE_IW-1:0] byte_idx;
  logic [NBYTES-1:0][BYTE_W-1:0] held, reg_val_a, ovh_a;

  assign reg_val_a = reg_val_i;
  assign ovh_o     = ovh_a;

  poh_timing #(.NBYTES(NBYTES), .BYTE_W(BYTE_W)) u_timing (
    .clk(clk), .rst(rst), .bit_en(bit_en_i), .samp_o(samp),
    .bit_idx_o(bit_idx), .byte_idx_o(byte_idx), .frame_end_o(frame_end),
    .ch_clk_o(ch_clk_o), .ch_sync_o(ch_sync_o)
  );

  poh_deser #(.NBYTES(NBYTES), .BYTE_W(BYTE_W), .PAR_SLOT(PAR_SLOT)) u_deser (
    .clk(clk), .rst(rst), .samp(samp), .bit_idx(bit_idx), .byte_idx(byte_idx),
    .frame_end(frame_end), .ser_i(ser_i), .odd_sel(odd_par_i),
    .held_o(held), .err_pulse_o(err_pulse)
  );

  poh_insert_sel #(.NBYTES(NBYTES), .BYTE_W(BYTE_W), .PAR_SLOT(PAR_SLOT)) u_sel (
    .clk(clk), .rst(rst), .reg_ins(reg_ins_i), .reg_val(reg_val_a),
    .ch_en(ch_en_i), .dflt_ones(dflt_ones_i), .held(held), .ovh_o(ovh_a)
  );

  always_ff @(posedge clk) begin
    if (rst) evt_q <= 1'b0;
    else     evt_q <= err_pulse | (evt_q & ~err_clr_i);
  end

  assign par_err_o = evt_q;
  assign irq_o     = evt_q & ~irq_mask_i;
endmodule

// File: rtl/poh_serial_port_chk.sv
module poh_serial_port_chk #(
  parameter int BYTE_W = poh_pkg::BYTE_W
) (
  input logic              clk,
  input logic              rst,
  input logic              bit_en_i,
  input logic              ch_clk_o,
  input logic              ch_sync_o,
  input logic              par_err_o,
  input logic              err_clr_i,
  input logic              dflt_ones_i,
  input logic [BYTE_W-1:0] par_slot
);
  logic       samp;
  logic [1:0] rise_cnt;
  assign samp = bit_en_i && ch_clk_o;

  always_ff @(posedge clk) begin
    if (rst) rise_cnt <= '0;
    else if ($rose(ch_sync_o) && rise_cnt != 2'd3) rise_cnt <= rise_cnt + 2'd1;
  end

  assert_clk_fall_on_sample_R1: assert property (@(posedge clk) disable iff (rst)
    samp |=> !ch_clk_o);
  assert_clk_rise_on_strobe_R1: assert property (@(posedge clk) disable iff (rst)
    (bit_en_i && !ch_clk_o) |=> ch_clk_o);
  assert_clk_idle_stable_R1: assert property (@(posedge clk) disable iff (rst)
    !bit_en_i |=> $stable(ch_clk_o));
  assert_sync_one_bit_R2: assert property (@(posedge clk) disable iff (rst)
    (samp && ch_sync_o) |=> !ch_sync_o);
  assert_err_at_frame_edge_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(par_err_o) |-> ch_sync_o);
  assert_no_err_first_frame_R5: assert property (@(posedge clk) disable iff (rst)
    (rise_cnt < 2'd2) |-> !par_err_o);
  assert_err_sticky_R6: assert property (@(posedge clk) disable iff (rst)
    (par_err_o && !err_clr_i) |=> par_err_o);
  assert_err_clear_R6: assert property (@(posedge clk) disable iff (rst)
    (err_clr_i && !ch_sync_o) |=> !par_err_o);
  assert_par_slot_default_R11: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (par_slot == {BYTE_W{$past(dflt_ones_i)}}));
endmodule

bind poh_serial_port poh_serial_port_chk #(.BYTE_W(BYTE_W)) chk_i (
  .clk(clk), .rst(rst), .bit_en_i(bit_en_i), .ch_clk_o(ch_clk_o),
  .ch_sync_o(ch_sync_o), .par_err_o(par_err_o), .err_clr_i(err_clr_i),
  .dflt_ones_i(dflt_ones_i), .par_slot(ovh_o[PAR_SLOT*BYTE_W +: BYTE_W])
);

// File: tb/poh_serial_port_tb_top.sv
module poh_serial_port_tb_top;
  localparam int NB = 9;
  localparam int BW = 8;
  localparam int W  = NB * BW;

  logic clk = 1'b0, rst = 1'b1, bit_en_i = 1'b0, ser_i = 1'b0;
  logic odd_par_i = 1'b0, dflt_ones_i = 1'b0, irq_mask_i = 1'b0, err_clr_i = 1'b0;
  logic [NB-1:0] reg_ins_i = '0, ch_en_i = '1;
  logic [W-1:0]  reg_val_i = '0;
  logic ch_clk_o, ch_sync_o, par_err_o, irq_o;
  logic [W-1:0] ovh_o;

  int nchk = 0, nerr = 0;
  typedef struct { logic err; logic [W-1:0] bytes; } item_t;
  item_t q[$];
  event frm_done;
  logic have_prev = 1'b0, prev_x = 1'b0, exp_evt = 1'b0;
  logic [W-1:0] prev_held = '0;

  always #5 clk = ~clk;

  poh_serial_port dut_i (
    .clk(clk), .rst(rst), .bit_en_i(bit_en_i), .ser_i(ser_i),
    .ch_clk_o(ch_clk_o), .ch_sync_o(ch_sync_o), .odd_par_i(odd_par_i),
    .reg_ins_i(reg_ins_i), .reg_val_i(reg_val_i), .ch_en_i(ch_en_i),
    .dflt_ones_i(dflt_ones_i), .irq_mask_i(irq_mask_i), .err_clr_i(err_clr_i),
    .ovh_o(ovh_o), .par_err_o(par_err_o), .irq_o(irq_o)
  );

  task automatic check(input logic ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] exp_ovh(input logic [W-1:0] b);
    logic [W-1:0] r;
    for (int k = 0; k < NB; k++) begin
      if (k == 1)            r[k*BW +: BW] = {BW{dflt_ones_i}};
      else if (reg_ins_i[k]) r[k*BW +: BW] = reg_val_i[k*BW +: BW];
      else if (ch_en_i[k])   r[k*BW +: BW] = b[k*BW +: BW];
      else                   r[k*BW +: BW] = {BW{dflt_ones_i}};
    end
    return r;
  endfunction

  // Driver: two strobes per bit, the first one is the sample strobe.
  task automatic send_frame(input logic [W-1:0] fr);
    item_t it;
    for (int b = 0; b < NB; b++) begin
      for (int i = BW - 1; i >= 0; i--) begin
        @(negedge clk);
        ser_i = fr[b*BW + i];
        check(ch_sync_o == (b == 0 && i == BW - 1), "R2 sync", W'(ch_sync_o), W'(b == 0 && i == BW - 1));
        if (b == 0 && i == BW - 1) check(ch_clk_o == 1'b1, "R1 clk high before sample", W'(ch_clk_o), W'(1));
        if (b == 4 && i == BW - 1) check(ovh_o == exp_ovh(prev_held), "R10 mid-frame hold", ovh_o, exp_ovh(prev_held));
        bit_en_i = 1'b1;
        @(negedge clk);
        bit_en_i = 1'b0;
        if (b == 0 && i == BW - 1) check(ch_clk_o == 1'b0, "R1 clk fall at sample", W'(ch_clk_o), W'(0));
        repeat (2) @(negedge clk);
        bit_en_i = 1'b1;
        @(negedge clk);
        bit_en_i = 1'b0;
        repeat (2) @(negedge clk);
      end
    end
    if (have_prev && (fr[1*BW + 7] ^ prev_x ^ odd_par_i)) exp_evt = 1'b1;
    prev_x    = ^fr;
    have_prev = 1'b1;
    prev_held = fr;
    it.err    = exp_evt;
    it.bytes  = fr;
    q.push_back(it);
    -> frm_done;
    repeat (6) @(negedge clk);
  endtask

  // Monitor: compares the design's result against the queued expectation.
  initial begin
    item_t it;
    forever begin
      @(frm_done);
      repeat (3) @(negedge clk);
      it = q.pop_front();
      check(par_err_o == it.err, "R4/R5 parity event", W'(par_err_o), W'(it.err));
      check(ovh_o == exp_ovh(it.bytes), "R3 received bytes", ovh_o, exp_ovh(it.bytes));
    end
  end

  function automatic logic [W-1:0] mk(input int seed, input logic pbit);
    logic [W-1:0] f;
    for (int k = 0; k < NB; k++) f[k*BW +: BW] = BW'(seed * 37 + k * 29 + 5);
    f[1*BW + 7] = pbit;
    return f;
  endfunction

  task automatic clear_evt();
    @(negedge clk); err_clr_i = 1'b1;
    @(negedge clk); err_clr_i = 1'b0;
    exp_evt = 1'b0;
  endtask

  initial begin
    logic [W-1:0] f;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(ch_sync_o && ch_clk_o, "R12 sync/clk reset", W'({ch_sync_o, ch_clk_o}), W'(3));
    check(!par_err_o && !irq_o, "R12 event reset", W'({par_err_o, irq_o}), W'(0));
    check(ovh_o == '0, "R12 ovh reset", ovh_o, '0);

    // R5: first frame carries a wrong parity bit, no event expected
    send_frame(mk(1, 1'b1));
    // even parity correct
    send_frame(mk(2, prev_x));
    // even parity wrong
    send_frame(mk(3, ~prev_x));
    check(irq_o == 1'b1, "R7 irq unmasked", W'(irq_o), W'(1));
    irq_mask_i = 1'b1;
    @(negedge clk);
    check(irq_o == 1'b0 && par_err_o, "R7 irq masked", W'({irq_o, par_err_o}), W'(1));
    repeat (20) @(negedge clk);
    check(par_err_o == 1'b1, "R6 sticky", W'(par_err_o), W'(1));
    clear_evt();
    @(negedge clk);
    check(par_err_o == 1'b0, "R6 cleared", W'(par_err_o), W'(0));
    irq_mask_i = 1'b0;

    // odd sense
    odd_par_i = 1'b1;
    send_frame(mk(4, ~prev_x));
    send_frame(mk(5, prev_x));
    clear_evt();
    odd_par_i = 1'b0;

    // source priority and defaults
    reg_ins_i[7] = 1'b1;
    reg_val_i[7*BW +: BW] = 8'hA5;
    reg_ins_i[1] = 1'b1;
    reg_val_i[1*BW +: BW] = 8'h3C;
    ch_en_i[8] = 1'b0;
    dflt_ones_i = 1'b1;
    repeat (3) @(negedge clk);
    check(ovh_o[7*BW +: BW] == 8'hA5, "R8 register wins", W'(ovh_o[7*BW +: BW]), W'(8'hA5));
    check(ovh_o[8*BW +: BW] == 8'hFF, "R9 default ones", W'(ovh_o[8*BW +: BW]), W'(8'hFF));
    check(ovh_o[1*BW +: BW] == 8'hFF, "R11 parity slot default", W'(ovh_o[1*BW +: BW]), W'(8'hFF));
    check(ovh_o == exp_ovh(prev_held), "R8 full bus", ovh_o, exp_ovh(prev_held));
    dflt_ones_i = 1'b0;
    repeat (3) @(negedge clk);
    check(ovh_o[8*BW +: BW] == 8'h00, "R9 default zeros", W'(ovh_o[8*BW +: BW]), W'(0));
    send_frame(mk(6, prev_x));

    // R5 again after a fresh reset
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    have_prev = 1'b0; exp_evt = 1'b0; prev_held = '0;
    send_frame(mk(7, ~prev_x));
    repeat (10) @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule